// File: doc/BRIEF.md
# Shift-Register Radix-2 FFT Engine

The engine computes an N-point discrete Fourier transform of complex fixed-point samples, N a power of two, with one butterfly reused over log2(N) passes. The block's words sit in two shift registers of N/2 words each: the "low" register holds the earlier half of the block and the "high" register the later half. Each pass streams both register heads through the butterfly. A delay line on the difference output and a two-way commutator reorder the results as they are written back into the register tails. The reordering uses no addressed memory.

A caller streams N samples in with `in_valid` and pulses `start`. `busy` stays high while the passes run. When `done` rises, the caller reads the N results one per `out_rd` pulse. Results come out in bit-reversed bin order, and `blk_exp` gives the number of passes that halved the whole array. Twiddle factors come from a small table that is computed when the design is elaborated.

Top module: `sr_fft`

## Requirements
- R1: The first N/2 loaded words fill the low register and the last N/2 fill the high register, in arrival order. The transform treats arrival position n as time index n.
- R2: `busy` rises one cycle after `start` is sampled in the idle state. The run lasts log2(N)·N/2 + N/2 − 1 cycles: every pass but the last adds N/2^(p+1) flush cycles to its N/2 streaming cycles. `done` follows the run, and `busy` and `done` are never high together.
- R3: Each butterfly forms A+B·W and A−B·W with W = exp(−j2πZ/N). After de-scaling by 2^blk_exp, the results match the exact DFT within 6 LSB.
- R4: Unloaded word k holds frequency bin bitrev(k), where bitrev reverses the log2(N) bits of k. A tone at bin m therefore peaks at unload position bitrev(m).
- R5: A pass halves all of its results, and adds one to `blk_exp`, exactly when some component entering that pass lies outside [−2^(DW−3), 2^(DW−3)). `blk_exp` never exceeds log2(N).
- R6: Inputs whose components all stay inside ±2^(DW−3), and that need no rotation (an impulse at time 0), transform exactly, with `blk_exp` = 0.
- R7: Input components inside ±2^(DW−2) never wrap. A constant input of 12000 scales on every pass and returns exactly 12000 in bin 0 and 0 elsewhere, with `blk_exp` = log2(N).
- R8: While `busy` is high, `in_valid` and `start` are ignored. The results and the run length are those of the block that was loaded.
- R9: `done` stays high until N words have been read. Each `out_rd` advances to the next word. After the N-th read the block returns to idle, with `done` low.
- R10: After reset, `busy`, `done` and `blk_exp` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load one sample (idle only) |
| in_re | input | DW | Sample real part, two's complement |
| in_im | input | DW | Sample imaginary part |
| start | input | 1 | Begin the transform (idle only) |
| out_rd | input | 1 | Advance to the next result word |
| busy | output | 1 | Passes in progress |
| done | output | 1 | Results ready to unload |
| out_re | output | DW | Current result real part |
| out_im | output | DW | Current result imaginary part |
| blk_exp | output | clog2(log2(N)+1) | Number of passes that halved the array |

## Verification
The hardest case to reach is a run whose scaling decision differs from pass to pass. Some passes must stay unscaled while later ones halve, so that the overflow flag carried across a pass boundary matters. A tone stimulus stays under the threshold at load time and crosses it only after the butterflies add coherently. A seeded random block near the input limit scales from the first pass. A constant full-range block and a small impulse pin the exponent at both extremes. During one run, garbage loads and start pulses are driven throughout the busy window to show that they cannot disturb the registers.

// File: rtl/sr_fft.sv
module sr_fft #(
  parameter int N  = 16,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic          start,
  input  logic          out_rd,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic [$clog2($clog2(N)+1)-1:0] blk_exp
);
  localparam int LG = $clog2(N);
  localparam int L  = N / 2;
  localparam int Q  = N / 4;
  localparam int QW = $clog2(Q);
  localparam int CW = 2 * DW;
  localparam int EW = $clog2(LG + 1);
  localparam int SB = TW - 2;
  localparam int PW = DW + TW + 2;
  localparam logic signed [PW-1:0] RH0 = PW'(1) << (SB - 1);
  localparam logic signed [PW-1:0] RH1 = PW'(1) << SB;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t st;

  logic [CW-1:0] ra [L];
  logic [CW-1:0] rb [L];
  logic [CW-1:0] dl [Q];
  logic [LG-1:0] t, pass, ld_cnt, uc, dly;
  logic [QW-1:0] dm1;
  logic [EW-1:0] expo;
  logic scl, big, last, pend, sw, sh_a, sh_b, wflag;
  logic [CW-1:0] ta, tb, ao, bo, bd;

  logic signed [TW-1:0] rom_r [L];
  logic signed [TW-1:0] rom_i [L];
  for (genvar k = 0; k < L; k++) begin : g_tw
    localparam real ANG = 6.283185307179586 * k / N;
    localparam int  CR  = $rtoi($floor($cos(ANG) * (2.0 ** SB) + 0.5));
    localparam int  CI  = $rtoi($floor(-$sin(ANG) * (2.0 ** SB) + 0.5));
    assign rom_r[k] = TW'(CR);
    assign rom_i[k] = TW'(CI);
  end

  function automatic logic hi(input logic [DW-1:0] v);
    return !(v[DW-1 -: 3] == 3'b000 || v[DW-1 -: 3] == 3'b111);
  endfunction
  function automatic logic wbig(input logic [CW-1:0] w);
    return hi(w[CW-1:DW]) | hi(w[DW-1:0]);
  endfunction
  function automatic logic [DW-1:0] rnd(input logic signed [PW-1:0] v, input logic s);
    logic signed [PW-1:0] r;
    r = s ? ((v + RH1) >>> (SB + 1)) : ((v + RH0) >>> SB);
    return r[DW-1:0];
  endfunction

  assign last = pass == LG'(LG);
  assign dly  = last ? '0 : LG'(N >> (pass + 1));
  assign dm1  = QW'(dly - 1'b1);
  assign pend = t == LG'(L - 1) + dly;
  assign sw   = (t & dly) == '0;
  assign bd   = dl[dm1];

  logic [LG-2:0] g, z;
  assign g = (LG-1)'(t >> (LG - pass));
  for (genvar i = 0; i < LG - 1; i++) begin : g_rev
    assign z[i] = g[LG-2-i];
  end

  logic signed [DW-1:0] a_r, a_i, b_r, b_i;
  logic signed [PW-1:0] xbr, xbi, xwr, xwi, p_r, p_i, al_r, al_i;
  assign a_r = ra[0][CW-1:DW];
  assign a_i = ra[0][DW-1:0];
  assign b_r = rb[0][CW-1:DW];
  assign b_i = rb[0][DW-1:0];
  assign xbr = PW'(b_r);
  assign xbi = PW'(b_i);
  assign xwr = PW'(rom_r[z]);
  assign xwi = PW'(rom_i[z]);
  assign p_r = xbr * xwr - xbi * xwi;
  assign p_i = xbr * xwi + xbi * xwr;
  assign al_r = PW'(a_r) <<< SB;
  assign al_i = PW'(a_i) <<< SB;
  assign ao = {rnd(al_r + p_r, scl), rnd(al_i + p_i, scl)};
  assign bo = {rnd(al_r - p_r, scl), rnd(al_i - p_i, scl)};

  always_comb begin
    sh_a = 1'b0;
    sh_b = 1'b0;
    ta = ra[0];
    tb = rb[0];
    wflag = 1'b0;
    case (st)
      S_IDLE: if (in_valid && !start) begin
        sh_a = !ld_cnt[LG-1];
        sh_b = ld_cnt[LG-1];
        ta = {in_re, in_im};
        tb = {in_re, in_im};
      end
      S_RUN: begin
        sh_a = !t[LG-1];
        sh_b = 1'b1;
        ta = (last || sw) ? ao : bd;
        tb = last ? bo : (sw ? bd : ao);
        wflag = (!t[LG-1] & wbig(ta)) | ((t >= dly) & wbig(tb));
      end
      S_DONE: if (out_rd) begin
        sh_a = !uc[0];
        sh_b = uc[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sh_a) begin
      for (int i = 0; i < L - 1; i++) ra[i] <= ra[i+1];
      ra[L-1] <= ta;
    end
    if (sh_b) begin
      for (int i = 0; i < L - 1; i++) rb[i] <= rb[i+1];
      rb[L-1] <= tb;
    end
    if (st == S_RUN) begin
      for (int i = Q - 1; i > 0; i--) dl[i] <= dl[i-1];
      dl[0] <= bo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      t <= '0;
      pass <= LG'(1);
      ld_cnt <= '0;
      uc <= '0;
      scl <= 1'b0;
      big <= 1'b0;
      expo <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN;
          t <= '0;
          pass <= LG'(1);
          scl <= big;
          big <= 1'b0;
          expo <= '0;
          ld_cnt <= '0;
        end else if (in_valid) begin
          ld_cnt <= ld_cnt + 1'b1;
          big <= (ld_cnt == '0) ? wbig({in_re, in_im}) : (big | wbig({in_re, in_im}));
        end
        S_RUN: begin
          t <= t + 1'b1;
          big <= big | wflag;
          if (pend) begin
            expo <= expo + EW'(scl);
            if (last) begin
              st <= S_DONE;
              uc <= '0;
            end else begin
              pass <= pass + 1'b1;
              t <= '0;
              scl <= big | wflag;
              big <= 1'b0;
            end
          end
        end
        S_DONE: if (out_rd) begin
          uc <= uc + 1'b1;
          if (uc == LG'(N - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = st == S_RUN;
  assign done    = st == S_DONE;
  assign out_re  = uc[0] ? rb[0][CW-1:DW] : ra[0][CW-1:DW];
  assign out_im  = uc[0] ? rb[0][DW-1:0]  : ra[0][DW-1:0];
  assign blk_exp = expo;
endmodule

// File: rtl/sr_fft_chk.sv
module sr_fft_chk #(
  parameter int LG = 4,
  parameter int EW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_rd,
  input logic          busy,
  input logic          done,
  input logic [EW-1:0] blk_exp
);
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !out_rd) |=> done);
  p_exp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (blk_exp == $past(blk_exp) || blk_exp == $past(blk_exp) + 1'b1));
  p_exp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_exp <= EW'(LG));
endmodule

bind sr_fft sr_fft_chk #(.LG(LG), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_rd(out_rd),
  .busy(busy), .done(done), .blk_exp(blk_exp)
);

// File: tb/sim_sr_fft.sv
module sim_sr_fft;
  localparam int N = 16, DW = 16, LG = 4, EW = 3;
  localparam int RUNLEN = LG * N / 2 + N / 2 - 1;

  logic clk = 0, rst_n = 0, in_valid = 0, start = 0, out_rd = 0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic busy, done;
  logic [DW-1:0] out_re, out_im;
  logic [EW-1:0] blk_exp;

  always #2 clk = ~clk;

  sr_fft #(.N(N), .DW(DW), .TW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .start(start), .out_rd(out_rd), .busy(busy), .done(done),
    .out_re(out_re), .out_im(out_im), .blk_exp(blk_exp)
  );

  int total = 0, bad = 0, cyc = 0;
  int xr[N], xi[N], gr[N], gi[N];
  int gexp, bcnt;
  int seed = 12345;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input real act, input real expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, expv);
    end
  endtask

  function automatic int brev(input int k);
    int r = 0;
    for (int i = 0; i < LG; i++) if (k[i]) r |= 1 << (LG - 1 - i);
    return r;
  endfunction

  task automatic run(input bit noisy);
    int guard = 0;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      in_valid = 1; in_re = DW'(xr[k]); in_im = DW'(xi[k]);
      @(negedge clk);
    end
    in_valid = 0; start = 1;
    @(negedge clk);
    start = 0;
    bcnt = 0;
    while (!done && guard < 1000) begin
      if (busy) bcnt++;
      in_valid = noisy && busy; start = noisy && busy;
      in_re = 16'h1234; in_im = 16'h7654;
      guard++;
      @(negedge clk);
    end
    in_valid = 0; start = 0;
    chk(done, "R2", "done reached", done, 1);
    chk(bcnt == RUNLEN, "R2", "busy cycles", bcnt, RUNLEN);
    gexp = blk_exp;
    repeat (3) @(negedge clk);
    chk(done && !busy, "R9", "done held without reads", done, 1);
    for (int k = 0; k < N; k++) begin
      gr[k] = $signed(out_re); gi[k] = $signed(out_im);
      out_rd = 1;
      @(negedge clk);
    end
    out_rd = 0;
    chk(!done && !busy, "R9", "idle after last read", done, 0);
  endtask

  task automatic cmp_dft(input string req);
    int nbad = 0;
    real er, ei, sc, wr, wi;
    sc = 2.0 ** gexp;
    for (int k = 0; k < N; k++) begin
      int m = brev(k);
      er = 0; ei = 0;
      for (int n = 0; n < N; n++) begin
        wr = $cos(6.283185307179586 * m * n / N);
        wi = $sin(6.283185307179586 * m * n / N);
        er += xr[n] * wr + xi[n] * wi;
        ei += xi[n] * wr - xr[n] * wi;
      end
      er /= sc; ei /= sc;
      if ((gr[k] - er > 6.0) || (er - gr[k] > 6.0) || (gi[k] - ei > 6.0) || (ei - gi[k] > 6.0)) begin
        nbad++;
        $display("FAIL %s bin %0d re/im actual=%0d/%0d expected=%0f/%0f", req, m, gr[k], gi[k], er, ei);
      end
    end
    total++;
    if (nbad != 0) bad++;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && blk_exp == 0, "R10", "reset outputs", {busy, done, blk_exp}, 0);
    rst_n = 1;
  endtask

  task automatic t_impulse;
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 1000;
    run(0);
    chk(gexp == 0, "R6", "impulse exponent", gexp, 0);
    for (int k = 0; k < N; k++)
      chk(gr[k] == 1000 && gi[k] == 0, "R6", "impulse exact", gr[k], 1000);
    cmp_dft("R1");
  endtask

  task automatic t_dc_full;
    for (int n = 0; n < N; n++) begin xr[n] = 12000; xi[n] = 0; end
    run(0);
    chk(gexp == LG, "R5", "exponent every pass", gexp, LG);
    chk(gr[0] == 12000 && gi[0] == 0, "R7", "dc bin exact", gr[0], 12000);
    for (int k = 1; k < N; k++)
      chk(gr[k] == 0 && gi[k] == 0, "R7", "non-dc bins zero", gr[k], 0);
  endtask

  task automatic t_tone;
    int best = 0, bk = -1;
    for (int n = 0; n < N; n++) begin
      xr[n] = $rtoi($floor(4000.0 * $cos(6.283185307179586 * 3 * n / N) + 0.5));
      xi[n] = $rtoi($floor(4000.0 * $sin(6.283185307179586 * 3 * n / N) + 0.5));
    end
    run(0);
    for (int k = 0; k < N; k++) begin
      int mg = gr[k] * gr[k] + gi[k] * gi[k];
      if (mg > best) begin best = mg; bk = k; end
    end
    chk(bk == brev(3), "R4", "tone peak position", bk, brev(3));
    chk(gexp > 0 && gexp < LG, "R5", "tone partial scaling", gexp, 2);
    cmp_dft("R3");
  endtask

  task automatic t_random(input bit noisy, input string req);
    for (int n = 0; n < N; n++) begin
      seed = seed * 1103515245 + 12345;
      xr[n] = ((seed >>> 8) % 24001);
      if (xr[n] < 0) xr[n] = -xr[n];
      xr[n] -= 12000;
      seed = seed * 1103515245 + 12345;
      xi[n] = ((seed >>> 8) % 24001);
      if (xi[n] < 0) xi[n] = -xi[n];
      xi[n] -= 12000;
    end
    run(noisy);
    cmp_dft(req);
  endtask

  initial begin
    t_reset;
    t_impulse;
    t_dc_full;
    t_tone;
    t_random(0, "R3");
    t_random(1, "R8");
    t_random(0, "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule